// File: doc/BRIEF.md
# Two-Strobe Presettable Up/Down Counter

This block is a binary counter that is moved by two separate strobes instead of an enable and a direction bit. A rising edge on the increment strobe adds one to the count, and a rising edge on the decrement strobe takes one away. Both strobes are asynchronous to the block, so they are retimed onto the system clock and their rising edges are found there. The count wraps around in both directions.

Two level-sensitive overrides act on the count. An active-high clear forces it to zero and wins over everything else. An active-low preset copies a data word into the count, and edges seen on the strobes meanwhile are dropped. The clear and preset inputs are retimed in the same way as the strobes. A control state machine has three states: `ST_RUN`, `ST_CLEAR` and `ST_LOAD`. Its next state is `ST_CLEAR` whenever the retimed clear is high. Otherwise it is `ST_LOAD` whenever the retimed preset is low, and otherwise `ST_RUN`. Each state issues one operation to the count register: zero it, preset it, or (in `ST_RUN`) increment, decrement, hold, or flag a clash.

Two active-low terminal outputs, carry and borrow, are idle high. Each one copies the low phase of its strobe while the count sits at its end value. This lets them drive the strobes of a following stage directly. A sticky collision flag records the case where both strobes rise in the same system cycle. In that case the count holds.

Top module: `updown_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb_i` raises `count_o` by one, while `dn_stb_i` stays high.
- R2: A rising edge on `dn_stb_i` lowers `count_o` by one, while `up_stb_i` stays high.
- R3: The count wraps modulo 2^WIDTH. An increment from all-ones gives zero, and a decrement from zero gives all-ones.
- R4: While `clear_i` is high, `count_o` becomes zero and `collide_o` is cleared. This holds whatever `load_n_i`, `data_i` and both strobes do.
- R5: While `load_n_i` is low and `clear_i` is low, `count_o` takes `data_i`. Strobe edges that arrive during the preset leave the count at `data_i`.
- R6: A strobe can be held low through a clear or a preset. Its first rising edge after the override is released is counted.
- R7: `carry_n_o` is low exactly when `count_o` is all-ones and the retimed `up_stb_i` is low. It is high otherwise.
- R8: `borrow_n_o` is low exactly when `count_o` is zero and the retimed `dn_stb_i` is low. It is high otherwise.
- R9: If rising edges of both strobes fall in the same system cycle, the count holds and `collide_o` goes high. `collide_o` stays high until a clear or a reset.
- R10: After `rst_n` is released, `count_o` is zero, `carry_n_o` and `borrow_n_o` are high, and `collide_o` is low.
- R11: An input change sampled at clock edge n affects `count_o` right after edge n+3 and not earlier. The terminal outputs follow a strobe level right after edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Active-high master clear (asynchronous, retimed) |
| load_n_i | input | 1 | Active-low preset (asynchronous, retimed) |
| data_i | input | WIDTH | Preset value, held stable while the preset is active |
| up_stb_i | input | 1 | Increment strobe, counts on its rising edge |
| dn_stb_i | input | 1 | Decrement strobe, counts on its rising edge |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low terminal output at the top of the range |
| borrow_n_o | output | 1 | Active-low terminal output at the bottom of the range |
| collide_o | output | 1 | Sticky flag for rising edges of both strobes in one cycle |

## Verification
The properties assume that `data_i` is steady while a preset is in progress, because the count copies it unretimed. They also assume that every strobe level lasts long enough to pass through the retiming flops. The stimulus changes every input only on the falling clock edge and holds each strobe level for at least four cycles. It keeps `data_i` fixed from before a preset begins until several cycles after it ends. The only deliberate violation of the one-strobe-at-a-time rule is a joint release of both strobes, which checks the clash handling.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CLEAR = 2'd1,
        ST_LOAD  = 2'd2
    } mode_t;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_DEC   = 3'd2,
        OP_CLR   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_CLASH = 3'd5
    } op_t;

endpackage

// File: rtl/udc_sync.sv
// Retiming chain for one asynchronous level onto the system clock.
module udc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/udc_edge.sv
// Registered rising-edge pulse from a retimed strobe level (idle high).
module udc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            rise_o <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            rise_o <= lvl_i & ~prev_q;
        end
    end
endmodule

// File: rtl/udc_ctrl_fsm.sv
// Control FSM: mode register plus the operation issued to the count.
module udc_ctrl_fsm
    import udc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_s_i,
    input  logic  load_n_s_i,
    input  logic  up_rise_i,
    input  logic  dn_rise_i,
    output mode_t mode_o,
    output op_t   op_o
);
    mode_t mode_q;
    mode_t mode_d;

    always_comb begin
        if (clear_s_i)       mode_d = ST_CLEAR;
        else if (!load_n_s_i) mode_d = ST_LOAD;
        else                 mode_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        op_o = OP_HOLD;
        unique case (mode_q)
            ST_CLEAR: op_o = OP_CLR;
            ST_LOAD:  op_o = OP_LOAD;
            ST_RUN: begin
                if (up_rise_i && dn_rise_i) op_o = OP_CLASH;
                else if (up_rise_i)         op_o = OP_INC;
                else if (dn_rise_i)         op_o = OP_DEC;
                else                        op_o = OP_HOLD;
            end
            default: op_o = OP_HOLD;
        endcase
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/udc_count_core.sv
// Count register, collision flag and terminal outputs.
module udc_count_core
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_t              op_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             up_lvl_i,
    input  logic             dn_lvl_i,
    output logic [WIDTH-1:0] count_o,
    output logic             collide_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic             col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            col_q <= 1'b0;
        end else begin
            unique case (op_i)
                OP_CLR: begin
                    cnt_q <= '0;
                    col_q <= 1'b0;
                end
                OP_LOAD:  cnt_q <= data_i;
                OP_INC:   cnt_q <= cnt_q + ONE;
                OP_DEC:   cnt_q <= cnt_q - ONE;
                OP_CLASH: col_q <= 1'b1;
                OP_HOLD:  cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o    = cnt_q;
    assign collide_o  = col_q;
    assign carry_n_o  = ~((cnt_q == TOP) & ~up_lvl_i);
    assign borrow_n_o = ~((cnt_q == '0)  & ~dn_lvl_i);
endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
    import udc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             up_stb_i,
    input  logic             dn_stb_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o,
    output logic             collide_o
);
    logic  clear_s, load_n_s, up_s, dn_s;
    logic  up_rise, dn_rise;
    mode_t mode_q;
    op_t   op;

    udc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_clr (
        .clk(clk), .rst_n(rst_n), .d_i(clear_i),  .q_o(clear_s));
    udc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .d_i(load_n_i), .q_o(load_n_s));
    udc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_up (
        .clk(clk), .rst_n(rst_n), .d_i(up_stb_i), .q_o(up_s));
    udc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_dn (
        .clk(clk), .rst_n(rst_n), .d_i(dn_stb_i), .q_o(dn_s));

    udc_edge u_edge_up (.clk(clk), .rst_n(rst_n), .lvl_i(up_s), .rise_o(up_rise));
    udc_edge u_edge_dn (.clk(clk), .rst_n(rst_n), .lvl_i(dn_s), .rise_o(dn_rise));

    udc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_s_i  (clear_s),
        .load_n_s_i (load_n_s),
        .up_rise_i  (up_rise),
        .dn_rise_i  (dn_rise),
        .mode_o     (mode_q),
        .op_o       (op)
    );

    udc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .data_i     (data_i),
        .up_lvl_i   (up_s),
        .dn_lvl_i   (dn_s),
        .count_o    (count_o),
        .collide_o  (collide_o),
        .carry_n_o  (carry_n_o),
        .borrow_n_o (borrow_n_o)
    );
endmodule

// File: rtl/udc_checker.sv
module udc_checker
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input mode_t            mode_q,
    input logic             up_rise,
    input logic             dn_rise,
    input logic             up_s,
    input logic             dn_s,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             collide_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1 R2 R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_RUN) |=> (count_o == $past(count_o) ||
                                count_o == $past(count_o) + ONE ||
                                count_o == $past(count_o) - ONE));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_CLEAR) |=> (count_o == '0 && !collide_o));

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_LOAD) |=> (count_o == $past(data_i)));

    // R7
    carry_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == TOP && !up_s));

    // R8
    borrow_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == '0 && !dn_s));

    // R9
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_RUN && up_rise && dn_rise) |=> (collide_o && $stable(count_o)));

    // R9
    clash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collide_o && mode_q != ST_CLEAR) |=> collide_o);
endmodule

bind updown_strobe_counter udc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .up_rise    (up_rise),
    .dn_rise    (dn_rise),
    .up_s       (up_s),
    .dn_s       (dn_s),
    .data_i     (data_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o),
    .collide_o  (collide_o)
);

// File: tb/updown_strobe_counter_tb.sv
`timescale 1ns/1ps
module updown_strobe_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       load_n_i = 1'b1;
    logic [3:0] data_i = 4'd0;
    logic       up_stb_i = 1'b1;
    logic       dn_stb_i = 1'b1;
    logic [3:0] count_o;
    logic       carry_n_o, borrow_n_o, collide_o;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    updown_strobe_counter u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
        .data_i(data_i), .up_stb_i(up_stb_i), .dn_stb_i(dn_stb_i),
        .count_o(count_o), .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o),
        .collide_o(collide_o));

    // Behavioural reference: input history, index 1 = newest sample.
    bit    h_up[1:4], h_dn[1:4], h_clr[1:4], h_ldn[1:4];
    int    m_cnt = 0;
    bit    m_err = 0;
    bit    m_carry_n = 1, m_borrow_n = 1;
    string m_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= 4; i++) begin
                h_up[i] = 1; h_dn[i] = 1; h_clr[i] = 0; h_ldn[i] = 1;
            end
            m_cnt = 0; m_err = 0; m_tag = "R10";
        end else begin
            bit ev_u, ev_d;
            ev_u = h_up[3] && !h_up[4];
            ev_d = h_dn[3] && !h_dn[4];
            if (h_clr[3]) begin
                m_cnt = 0; m_err = 0; m_tag = "R4";
            end else if (!h_ldn[3]) begin
                m_cnt = int'(data_i); m_tag = "R5";
            end else if (ev_u && ev_d) begin
                m_err = 1; m_tag = "R9";
            end else if (ev_u) begin
                m_tag = (m_cnt == 15) ? "R3" : "R1";
                m_cnt = (m_cnt + 1) % 16;
            end else if (ev_d) begin
                m_tag = (m_cnt == 0) ? "R3" : "R2";
                m_cnt = (m_cnt + 15) % 16;
            end else begin
                m_tag = "R11";
            end
            for (int i = 4; i > 1; i--) begin
                h_up[i] = h_up[i-1]; h_dn[i] = h_dn[i-1];
                h_clr[i] = h_clr[i-1]; h_ldn[i] = h_ldn[i-1];
            end
            h_up[1] = up_stb_i; h_dn[1] = dn_stb_i;
            h_clr[1] = clear_i; h_ldn[1] = load_n_i;
        end
        m_carry_n  = !(m_cnt == 15 && !h_up[2]);
        m_borrow_n = !(m_cnt == 0 && !h_dn[2]);
    end

    task automatic check(input string tag, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(m_tag, int'(count_o), m_cnt);
            check("R7", int'(carry_n_o), int'(m_carry_n));
            check("R8", int'(borrow_n_o), int'(m_borrow_n));
            check("R9", int'(collide_o), int'(m_err));
        end
    end

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            total++; fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            summary();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic up_pulse();
        up_stb_i = 0; tick(4); up_stb_i = 1; tick(5);
    endtask

    task automatic dn_pulse();
        dn_stb_i = 0; tick(4); dn_stb_i = 1; tick(5);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R10: reset state
        check("R10", int'(count_o), 0);
        check("R10", int'(carry_n_o), 1);
        check("R10", int'(borrow_n_o), 1);
        check("R10", int'(collide_o), 0);

        // R4: clear
        clear_i = 1; tick(5); clear_i = 0; tick(5);
        check("R4", int'(count_o), 0);

        // R5: preset to 13
        data_i = 4'd13; load_n_i = 0; tick(5); load_n_i = 1; tick(5);
        check("R5", int'(count_o), 13);

        // R1: up to 14, 15
        up_pulse(); check("R1", int'(count_o), 14);
        up_pulse(); check("R1", int'(count_o), 15);

        // R7 and R3: carry low at 15 while strobe low, then wrap to 0
        up_stb_i = 0; tick(4);
        check("R7", int'(carry_n_o), 0);
        up_stb_i = 1; tick(5);
        check("R3", int'(count_o), 0);
        check("R7", int'(carry_n_o), 1);
        up_pulse(); up_pulse();
        check("R1", int'(count_o), 2);

        // R2: down to 1, 0
        dn_pulse(); check("R2", int'(count_o), 1);
        dn_pulse(); check("R2", int'(count_o), 0);

        // R8 and R3: borrow at 0, wrap to 15
        dn_stb_i = 0; tick(4);
        check("R8", int'(borrow_n_o), 0);
        dn_stb_i = 1; tick(5);
        check("R3", int'(count_o), 15);
        check("R8", int'(borrow_n_o), 1);

        // R11: latency of an increment (15 -> 0)
        up_stb_i = 0; tick(5);
        up_stb_i = 1;
        tick(3); check("R11", int'(count_o), 15);
        tick(1); check("R11", int'(count_o), 0);
        tick(4);

        // R9: both strobes rise together
        up_pulse();
        up_stb_i = 0; dn_stb_i = 0; tick(4);
        up_stb_i = 1; dn_stb_i = 1; tick(5);
        check("R9", int'(count_o), 1);
        check("R9", int'(collide_o), 1);
        up_pulse();
        check("R9", int'(collide_o), 1);
        check("R1", int'(count_o), 2);
        clear_i = 1; tick(5); clear_i = 0; tick(5);
        check("R4", int'(collide_o), 0);

        // R5: strobe edges during preset are dropped
        data_i = 4'd6; load_n_i = 0; tick(5);
        up_pulse(); dn_pulse(); up_pulse();
        check("R5", int'(count_o), 6);
        load_n_i = 1; tick(5);
        check("R5", int'(count_o), 6);

        // R4: clear wins over preset and strobes
        data_i = 4'd9; clear_i = 1; load_n_i = 0;
        tick(5); up_pulse();
        check("R4", int'(count_o), 0);
        clear_i = 0; load_n_i = 1; tick(5);
        check("R4", int'(count_o), 0);

        // R6: strobe held low through clear, next rise counts
        up_stb_i = 0; tick(2);
        clear_i = 1; tick(4); clear_i = 0; tick(5);
        check("R6", int'(count_o), 0);
        up_stb_i = 1; tick(5);
        check("R6", int'(count_o), 1);

        // R6: strobe held low through preset
        dn_stb_i = 0; tick(2);
        data_i = 4'd4; load_n_i = 0; tick(4); load_n_i = 1; tick(5);
        check("R6", int'(count_o), 4);
        dn_stb_i = 1; tick(5);
        check("R6", int'(count_o), 3);

        summary();
    end
endmodule